// File: doc/BRIEF.md
# Level Wake-Up Qualifier

This block watches a group of active-low level interrupt lines while the device sleeps. It runs on the slow free-running oscillator clock, which has a nominal period of 1 µs. Only lines that are both enabled and set to level mode take part. A line must read low on two back-to-back slow-clock samples before the block emits a wake pulse. This keeps short glitches from waking the device.

After the wake pulse, a start-up counter runs for a length picked by a 2-bit setting. When the count ends, the block looks at the qualifying lines again. It raises an interrupt, together with the set of lines that are still low, only if at least one of them is still held. A wake can therefore happen with no interrupt at all, when the level goes away during start-up. After an episode, a new wake needs the sleep indicator to drop and then rise again.

Top module: `lwq_top`

## Requirements
- R1: After a synchronous reset, `wake_o`, `irq_o` and `irq_src_o` are all zero.
- R2: A line qualifies only when its enable bit and its level-mode bit are both 1. A low level on any other line causes no wake and never appears in `irq_src_o`.
- R3: A qualifying line (pin value 0 means asserted) must be sampled low on two consecutive clock edges. A low that is seen on only one edge causes no wake.
- R4: `wake_o` is a one-cycle pulse. It goes high in the cycle after the edge that takes the second low sample.
- R5: `sut_sel_i` picks the start-up length D: 0 gives 0 cycles, 1 gives 4, 2 gives 64 and 3 gives 1024. The level check takes place D+1 cycles after the wake pulse, and `irq_o` is high in that cycle only.
- R6: `irq_o` pulses only if some qualifying line is still low at the edge where the check is made. Otherwise the episode ends with a wake and no interrupt.
- R7: `irq_src_o` has bit n set when line n is qualifying and low at the check. It is zero in every cycle where `irq_o` is low.
- R8: After a wake, no further wake occurs while `sleep_i` stays high. The block rearms only after `sleep_i` has been low for at least one edge and then goes high again.
- R9: While `sleep_i` is low, no wake occurs, whatever the lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | N_LINES | Line levels, low is asserted |
| line_en_i | input | N_LINES | Per-line enable |
| line_lvl_i | input | N_LINES | Per-line level-mode select |
| sleep_i | input | 1 | Device is in deep sleep |
| sut_sel_i | input | 2 | Start-up length select |
| wake_o | output | 1 | One-cycle wake request |
| irq_o | output | 1 | One-cycle interrupt-valid pulse |
| irq_src_o | output | N_LINES | Lines still low at the check |

## Verification
The start-up check and the release of the line can land on the same edge. This decides whether an episode ends in an interrupt or only in a wake. For every start-up length, the bench releases the line one cycle before the check edge and also exactly after it. It expects no interrupt in the first case and an interrupt in the second. The same sweep moves the release across the two-sample window, so a single low sample and a wake on the second sample are judged against the cycle numbers worked out from the requirements.

// File: rtl/lwq_pkg.sv
package lwq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_START = 2'd2,
    ST_DONE  = 2'd3
  } lwq_state_e;
endpackage

// File: rtl/lwq_sampler.sv
module lwq_sampler #(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [N_LINES-1:0] pin_lvl,
  input  logic [N_LINES-1:0] elig,
  output logic [N_LINES-1:0] low_now,
  output logic [N_LINES-1:0] hit
);
  logic [N_LINES-1:0] smp_q;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign low_now[g] = elig[g] & ~pin_lvl[g];

    always_ff @(posedge clk) begin
      if (rst || clr) smp_q[g] <= 1'b0;
      else            smp_q[g] <= low_now[g];
    end

    assign hit[g] = smp_q[g] & low_now[g];

    // R3: a hit needs the line to have been low and qualifying on the previous edge
    a_r3_two_samples: assert property (@(posedge clk) disable iff (rst)
      hit[g] |-> $past(elig[g] & ~pin_lvl[g]));
  end
endmodule

// File: rtl/lwq_delay.sv
module lwq_delay #(
  parameter int D0 = 0,
  parameter int D1 = 4,
  parameter int D2 = 64,
  parameter int D3 = 1024,
  parameter int CW = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] sel,
  input  logic       run,
  output logic       expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (sel)
      2'd0:    load_val = CW'(D0);
      2'd1:    load_val = CW'(D1);
      2'd2:    load_val = CW'(D2);
      default: load_val = CW'(D3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == '0);

  // R5: the count never wraps while running
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !load && $past(run) && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/lwq_top.sv
module lwq_top #(
  parameter int N_LINES = 4,
  parameter int D0 = 0,
  parameter int D1 = 4,
  parameter int D2 = 64,
  parameter int D3 = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] pin_lvl_i,
  input  logic [N_LINES-1:0] line_en_i,
  input  logic [N_LINES-1:0] line_lvl_i,
  input  logic               sleep_i,
  input  logic [1:0]         sut_sel_i,
  output logic               wake_o,
  output logic               irq_o,
  output logic [N_LINES-1:0] irq_src_o
);
  import lwq_pkg::*;

  localparam int CW = $clog2(D3 + 1);

  lwq_state_e         state_q;
  logic [N_LINES-1:0] elig, low_now, hit;
  logic               samp_clr, load, run, expire;
  logic               wake_q, irq_q;
  logic [N_LINES-1:0] src_q;

  assign elig     = line_en_i & line_lvl_i;
  assign samp_clr = (state_q != ST_ARMED) || !sleep_i;
  assign load     = (state_q == ST_ARMED) && sleep_i && (|hit);
  assign run      = (state_q == ST_START);

  lwq_sampler #(.N_LINES(N_LINES)) u_samp (
    .clk(clk), .rst(rst), .clr(samp_clr), .pin_lvl(pin_lvl_i),
    .elig(elig), .low_now(low_now), .hit(hit)
  );

  lwq_delay #(.D0(D0), .D1(D1), .D2(D2), .D3(D3), .CW(CW)) u_dly (
    .clk(clk), .rst(rst), .load(load), .sel(sut_sel_i),
    .run(run), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wake_q  <= 1'b0;
      irq_q   <= 1'b0;
      src_q   <= '0;
    end else begin
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
      src_q  <= '0;
      unique case (state_q)
        ST_IDLE:  if (sleep_i) state_q <= ST_ARMED;
        ST_ARMED: begin
          if (!sleep_i) state_q <= ST_IDLE;
          else if (load) begin
            wake_q  <= 1'b1;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (expire) begin
            if (|low_now) begin
              irq_q <= 1'b1;
              src_q <= low_now;
            end
            state_q <= ST_DONE;
          end
        end
        default:  if (!sleep_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assign wake_o    = wake_q;
  assign irq_o     = irq_q;
  assign irq_src_o = src_q;

  // R4: wake is a single-cycle pulse
  a_r4_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);
  // R5: interrupt is a single-cycle pulse
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R6: an interrupt always names at least one line
  a_r6_irq_has_src: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|irq_src_o));
  // R7: source vector is zero outside the interrupt pulse
  a_r7_src_quiet: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (irq_src_o == '0));
  // R8: no second wake while the episode has finished and sleep holds
  a_r8_no_rearm: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> !wake_o);
  // R9: a wake needs sleep at the deciding edge
  a_r9_sleep_needed: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> $past(sleep_i));
endmodule

// File: tb/tb_lwq_top.sv
`timescale 1ns/1ps
module tb_lwq_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] pin_lvl, line_en, line_lvl;
  logic         sleep;
  logic [1:0]   sut_sel;
  logic         wake, irq;
  logic [N-1:0] irq_src;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lwq_top #(.N_LINES(N)) dut (
    .clk(clk), .rst(rst), .pin_lvl_i(pin_lvl), .line_en_i(line_en),
    .line_lvl_i(line_lvl), .sleep_i(sleep), .sut_sel_i(sut_sel),
    .wake_o(wake), .irq_o(irq), .irq_src_o(irq_src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dly(input int sel);
    case (sel)
      0: return 0;
      1: return 4;
      2: return 64;
      default: return 1024;
    endcase
  endfunction

  task automatic arm();
    sleep = 1'b0;
    @(negedge clk); @(negedge clk);
    sleep = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  // Pull lines in mask low for 'hold' edges and compare every cycle.
  task automatic episode(input logic [N-1:0] mask, input int sel, input int hold);
    int d = dly(sel);
    logic [N-1:0] q = mask & line_en & line_lvl;
    bit wexp_any = (q != 0) && (hold >= 2);
    bit iexp_any = wexp_any && (hold >= 3 + d);
    int wbad = 0, ibad = 0, sbad = 0, wseen = 0, iseen = 0;
    sut_sel = 2'(sel);
    pin_lvl = ~mask;
    for (int k = 1; k <= 6 + d; k++) begin
      @(negedge clk);
      begin
        bit we = wexp_any && (k == 2);
        bit ie = iexp_any && (k == 3 + d);
        if (wake !== we) wbad++;
        if (irq !== ie) ibad++;
        if (irq_src !== (ie ? q : '0)) sbad++;
        wseen += int'(wake);
        iseen += int'(irq);
      end
      if (k == hold) pin_lvl = '1;
    end
    pin_lvl = '1;
    chk(wbad == 0, "R3/R4 wake timing", wseen, int'(wexp_any));
    chk(ibad == 0, "R5/R6 irq timing", iseen, int'(iexp_any));
    chk(sbad == 0, "R7 irq_src", sbad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pin_lvl = '1; line_en = '1; line_lvl = '1; sleep = 1'b0; sut_sel = 2'd0;
    repeat (3) @(negedge clk);
    chk(wake === 1'b0 && irq === 1'b0 && irq_src === '0, "R1 reset", int'(wake), 0);
    rst = 1'b0;

    // R9: low level while awake -> no wake
    pin_lvl = 4'b1110;
    begin
      int seen = 0;
      repeat (6) begin @(negedge clk); seen += int'(wake); end
      chk(seen == 0, "R9 no wake while awake", seen, 0);
    end
    pin_lvl = '1;

    // R3/R5/R6: sweep start-up length and release point
    for (int s = 0; s < 4; s++) begin
      int d = dly(s);
      int holds[4] = '{1, 2 + d, 3 + d, 8 + d};
      for (int h = 0; h < 4; h++) begin
        arm();
        episode(4'b0001 << (s % N), s, holds[h]);
      end
    end

    // R2: every enable/mode combination per line
    for (int l = 0; l < N; l++) begin
      for (int c = 0; c < 4; c++) begin
        line_en  = '1; line_lvl = '1;
        line_en[l]  = c[0];
        line_lvl[l] = c[1];
        arm();
        episode(4'b0001 << l, 0, 10);
      end
    end
    line_en = '1; line_lvl = '1;

    // R7: two lines together, one not qualifying
    line_lvl = 4'b1011;
    arm();
    episode(4'b0101 | 4'b0100 | 4'b1000, 1, 20);
    line_lvl = '1;

    // R8: no rearm while sleep stays high
    arm();
    episode(4'b0010, 0, 10);
    pin_lvl = 4'b1101;
    begin
      int seen = 0;
      repeat (10) begin @(negedge clk); seen += int'(wake); end
      chk(seen == 0, "R8 no wake before rearm", seen, 0);
    end
    pin_lvl = '1;
    // R8: after sleep drops and rises again, a wake occurs once more
    arm();
    episode(4'b0010, 0, 10);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule